// File: doc/BRIEF.md
# Store buffer with load forwarding

This block holds stores that have already committed, in program order, until memory has taken and acknowledged each one. New entries go in at the tail. Each cycle the block offers the oldest not-yet-sent stores to a memory request port on a set of parallel issue lanes, and it releases entries from the head once their write acknowledgements have come back. Ordering barriers may be placed in the buffer like stores. A barrier is never sent to memory: it holds back every entry behind it, and it is removed once it reaches the head, at which point a clear pulse is raised.

A load lookup port lets the core ask whether a load can take its data from a buffered store. The load's byte range is compared with every eligible entry, youngest first, and the first entry that overlaps decides the answer. The answer is no overlap, partial overlap or full cover, together with the slot that decided it. On full cover the forwarded bytes come back as well.

Top module: `stq_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty: `ins_ready` is 1, `unissued` is 0, `iss_valid` is all zero even with `mem_ready` high, `bar_clr` is 0 and `lk_done` is 0.
- R2: `ins_ready` is 1 only while fewer than SLOTS entries are occupied. An insert offered while `ins_ready` is 0 is dropped: it is never issued and is never seen by a lookup.
- R3: A load `[A, A+S)` against a store `[B, B+T)` is none when A >= B+T or A+S <= B, full when B <= A and B+T >= A+S, and partial otherwise. `lk_cover` encodes none as 2'b00, partial as 2'b01 and full as 2'b10. It is valid, with `lk_done` high, in the cycle after `lk_valid`.
- R4: The search runs from the youngest entry to the oldest. The first entry that overlaps gives both `lk_cover` and `lk_slot`, even when an older entry would give a different answer.
- R5: Only stores with the load's thread id take part in the search. Barrier entries and cache-maintenance entries (`ins_cmo`=1) never do.
- R6: On full cover, `lk_data` byte i is store byte (A−B+i) for i < S, and all higher bytes are zero. Data is byte-addressed and little-endian: byte k of `ins_data` belongs to address `ins_addr`+k. `lk_data` is zero when the result is not full.
- R7: While `mem_ready` is 1, lane j of `iss_valid` presents the j-th oldest unsent entry, for up to LANES entries in buffer order. Each lane carries that entry's address, size, data and slot. No lane is valid while `mem_ready` is 0.
- R8: A lane that is valid and has its `mem_nack` bit set is refused, and so is every lane after it. The refused entry stays unsent. No lane is valid again until a `mem_retry` pulse has been seen.
- R9: A barrier stops issue of every entry younger than itself. It is removed once it reaches the head, and `bar_clr` is high for the one cycle in which it sits at the head.
- R10: `unissued` rises by one for each accepted insert and falls by one for each lane accepted by memory and for each barrier removed.
- R11: `mem_ack` with `mem_ack_slot` marks that sent store as written. Entries leave only from the head, one per cycle, so an acknowledgement for a younger store frees nothing until every older store has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ins_valid | input | 1 | Insert an entry at the tail |
| ins_barrier | input | 1 | Entry is a barrier |
| ins_cmo | input | 1 | Entry is a cache-maintenance operation |
| ins_tid | input | TID_W (2) | Thread id of the entry |
| ins_addr | input | ADDR_W (16) | Byte address of the store |
| ins_size | input | SIZE_W (4) | Store size in bytes, 1..DATA_BYTES |
| ins_data | input | DW (64) | Store data, byte 0 at ins_addr |
| ins_ready | output | 1 | A free slot exists |
| mem_ready | input | 1 | Memory port can take requests this cycle |
| mem_nack | input | LANES (2) | Per-lane refusal of the offered request |
| mem_retry | input | 1 | Memory is ready again after a refusal |
| mem_ack | input | 1 | Write acknowledgement |
| mem_ack_slot | input | PTR_W (2) | Slot being acknowledged |
| iss_valid | output | LANES (2) | Lane holds a request |
| iss_addr | output | LANES*ADDR_W (32) | Lane addresses |
| iss_size | output | LANES*SIZE_W (8) | Lane sizes |
| iss_data | output | LANES*DW (128) | Lane data |
| iss_slot | output | LANES*PTR_W (4) | Lane slot indices, used as the acknowledgement tag |
| lk_valid | input | 1 | Start a load lookup |
| lk_tid | input | TID_W (2) | Thread id of the load |
| lk_addr | input | ADDR_W (16) | Load byte address |
| lk_size | input | SIZE_W (4) | Load size in bytes |
| lk_done | output | 1 | Lookup result valid |
| lk_cover | output | 2 | 00 none, 01 partial, 10 full |
| lk_slot | output | PTR_W (2) | Slot that decided the result |
| lk_data | output | DW (64) | Forwarded bytes on full cover |
| bar_clr | output | 1 | A barrier is being removed from the head |
| unissued | output | CNT_W (3) | Entries not yet sent or cleared |

## Verification
The hardest state to reach is a barrier sitting behind a store that has been sent but not acknowledged. The barrier must then hold back a younger store while `mem_ready` stays high, and `bar_clr` must pulse for exactly one cycle once the older store retires. The bench builds this state on purpose: it inserts store, barrier, store, lets only the first one issue, and delays the acknowledgement for a few cycles. It then checks the issue lanes, `bar_clr` and `unissued` on each of the following edges. A refused lane is reached in a similar way: the bench nacks the second of two lanes, holds `mem_ready` high through the wait, and only then sends the retry pulse.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
   typedef enum logic [1:0] {
      COV_NONE = 2'b00,
      COV_PART = 2'b01,
      COV_FULL = 2'b10
   } cov_e;
endpackage

// File: rtl/sfb_cover.sv
module sfb_cover
   import sfb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SIZE_W = 4
) (
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [SIZE_W-1:0] ld_size,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SIZE_W-1:0] st_size,
   output cov_e              cov
);
   localparam int AW1 = ADDR_W + 1;

   logic [AW1-1:0] ld_lo, ld_hi, st_lo, st_hi;

   always_comb begin
      ld_lo = {1'b0, ld_addr};
      st_lo = {1'b0, st_addr};
      ld_hi = ld_lo + AW1'(ld_size);
      st_hi = st_lo + AW1'(st_size);
      if (ld_lo >= st_hi || ld_hi <= st_lo)
         cov = COV_NONE;
      else if (st_lo <= ld_lo && st_hi >= ld_hi)
         cov = COV_FULL;
      else
         cov = COV_PART;
   end
endmodule

// File: rtl/sfb_issue.sv
module sfb_issue #(
   parameter int SLOTS = 4,
   parameter int LANES = 2,
   parameter int PTR_W = 2,
   parameter int CNT_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PTR_W-1:0]       head,
   input  logic [CNT_W-1:0]       count,
   input  logic [CNT_W-1:0]       iss_off,
   input  logic [SLOTS-1:0]       ent_bar,
   input  logic                   mem_ready,
   input  logic                   retry_wait,
   input  logic [LANES-1:0]       nack,
   output logic [LANES-1:0]       lane_valid,
   output logic [LANES*PTR_W-1:0] lane_slot,
   output logic [CNT_W-1:0]       n_acc,
   output logic                   refused
);
   always_comb begin
      logic chain;
      logic acc_chain;
      chain      = mem_ready & ~retry_wait;
      acc_chain  = 1'b1;
      n_acc      = '0;
      refused    = 1'b0;
      lane_valid = '0;
      lane_slot  = '0;
      for (int j = 0; j < LANES; j++) begin
         logic [PTR_W-1:0] pos;
         int               off;
         logic             ok;
         off = int'(iss_off) + j;
         pos = head + PTR_W'(off);
         ok  = chain && (off < int'(count)) && !ent_bar[pos];
         lane_valid[j]                 = ok;
         lane_slot[j*PTR_W +: PTR_W]   = pos;
         chain     = ok;
         acc_chain = acc_chain & ok & ~nack[j];
         if (acc_chain) n_acc = n_acc + CNT_W'(1);
         if (ok && nack[j]) refused = 1'b1;
      end
   end

   // R7: nothing is offered while the port cannot accept
   assert_no_issue_unready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ready |-> lane_valid == '0);

   // R7: lanes fill from lane 0 upward without gaps
   generate
      for (genvar j = 1; j < LANES; j++) begin : g_chk
         assert_lane_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
            lane_valid[j] |-> lane_valid[j-1]);
      end
   endgenerate
endmodule

// File: rtl/stq_fwd_buffer.sv
module stq_fwd_buffer
   import sfb_pkg::*;
#(
   parameter int SLOTS      = 4,
   parameter int ADDR_W     = 16,
   parameter int DATA_BYTES = 8,
   parameter int TID_W      = 2,
   parameter int LANES      = 2,
   localparam int PTR_W     = $clog2(SLOTS),
   localparam int CNT_W     = $clog2(SLOTS + 1),
   localparam int SIZE_W    = $clog2(DATA_BYTES + 1),
   localparam int DW        = DATA_BYTES * 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ins_valid,
   input  logic                    ins_barrier,
   input  logic                    ins_cmo,
   input  logic [TID_W-1:0]        ins_tid,
   input  logic [ADDR_W-1:0]       ins_addr,
   input  logic [SIZE_W-1:0]       ins_size,
   input  logic [DW-1:0]           ins_data,
   output logic                    ins_ready,
   input  logic                    mem_ready,
   input  logic [LANES-1:0]        mem_nack,
   input  logic                    mem_retry,
   input  logic                    mem_ack,
   input  logic [PTR_W-1:0]        mem_ack_slot,
   output logic [LANES-1:0]        iss_valid,
   output logic [LANES*ADDR_W-1:0] iss_addr,
   output logic [LANES*SIZE_W-1:0] iss_size,
   output logic [LANES*DW-1:0]     iss_data,
   output logic [LANES*PTR_W-1:0]  iss_slot,
   input  logic                    lk_valid,
   input  logic [TID_W-1:0]        lk_tid,
   input  logic [ADDR_W-1:0]       lk_addr,
   input  logic [SIZE_W-1:0]       lk_size,
   output logic                    lk_done,
   output logic [1:0]              lk_cover,
   output logic [PTR_W-1:0]        lk_slot,
   output logic [DW-1:0]           lk_data,
   output logic                    bar_clr,
   output logic [CNT_W-1:0]        unissued
);
   localparam int OFF_W = $clog2(DATA_BYTES);

   generate
      if (SLOTS < 2 || (1 << PTR_W) != SLOTS) begin : g_bad_slots
         $error("SLOTS must be a power of two of at least 2");
      end
      if (LANES < 1 || LANES > SLOTS) begin : g_bad_lanes
         $error("LANES must lie in 1..SLOTS");
      end
      if (DATA_BYTES < 2) begin : g_bad_bytes
         $error("DATA_BYTES must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] ent_addr [SLOTS];
   logic [SIZE_W-1:0] ent_size [SLOTS];
   logic [DW-1:0]     ent_data [SLOTS];
   logic [TID_W-1:0]  ent_tid  [SLOTS];
   logic [SLOTS-1:0]  ent_bar, ent_cmo, ent_done;

   logic [PTR_W-1:0]  head;
   logic [CNT_W-1:0]  count, iss_off;
   logic              retry_wait;

   logic [PTR_W-1:0]  tail;
   logic              ins_fire, pop, pop_bar, pop_store;
   logic [CNT_W-1:0]  n_acc;
   logic              refused;
   logic [LANES*PTR_W-1:0] lane_slot;

   assign tail      = head + count[PTR_W-1:0];
   assign ins_ready = (count < CNT_W'(SLOTS));
   assign ins_fire  = ins_valid & ins_ready;
   assign pop       = (count != '0) && (ent_bar[head] || ent_done[head]);
   assign pop_bar   = pop & ent_bar[head];
   assign pop_store = pop & ~ent_bar[head];
   assign bar_clr   = pop_bar;

   // ---------------- issue lanes ----------------
   sfb_issue #(.SLOTS(SLOTS), .LANES(LANES), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_issue (
      .clk(clk), .rst_n(rst_n), .head(head), .count(count), .iss_off(iss_off),
      .ent_bar(ent_bar), .mem_ready(mem_ready), .retry_wait(retry_wait),
      .nack(mem_nack), .lane_valid(iss_valid), .lane_slot(lane_slot),
      .n_acc(n_acc), .refused(refused));

   assign iss_slot = lane_slot;

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         assign iss_addr[j*ADDR_W +: ADDR_W] = ent_addr[lane_slot[j*PTR_W +: PTR_W]];
         assign iss_size[j*SIZE_W +: SIZE_W] = ent_size[lane_slot[j*PTR_W +: PTR_W]];
         assign iss_data[j*DW +: DW]         = ent_data[lane_slot[j*PTR_W +: PTR_W]];
      end
   endgenerate

   // ---------------- storage ----------------
   always_ff @(posedge clk) begin
      if (ins_fire) begin
         ent_addr[tail] <= ins_addr;
         ent_size[tail] <= ins_size;
         ent_data[tail] <= ins_data;
         ent_tid[tail]  <= ins_tid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_bar    <= '0;
         ent_cmo    <= '0;
         ent_done   <= '0;
         head       <= '0;
         count      <= '0;
         iss_off    <= '0;
         unissued   <= '0;
         retry_wait <= 1'b0;
      end else begin
         if (ins_fire) begin
            ent_bar[tail]  <= ins_barrier;
            ent_cmo[tail]  <= ins_cmo;
            ent_done[tail] <= 1'b0;
         end
         if (mem_ack) ent_done[mem_ack_slot] <= 1'b1;
         if (pop) begin
            ent_done[head] <= 1'b0;
            head           <= head + PTR_W'(1);
         end
         count    <= count + CNT_W'(ins_fire) - CNT_W'(pop);
         iss_off  <= iss_off + n_acc - CNT_W'(pop_store);
         unissued <= unissued + CNT_W'(ins_fire) - n_acc - CNT_W'(pop_bar);
         if (refused)        retry_wait <= 1'b1;
         else if (mem_retry) retry_wait <= 1'b0;
      end
   end

   // ---------------- load lookup ----------------
   cov_e             slot_cov  [SLOTS];
   logic [SLOTS-1:0] slot_cand;

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         sfb_cover #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_cov (
            .ld_addr(lk_addr), .ld_size(lk_size),
            .st_addr(ent_addr[s]), .st_size(ent_size[s]), .cov(slot_cov[s]));
         assign slot_cand[s] = ~ent_bar[s] & ~ent_cmo[s] & (ent_tid[s] == lk_tid);
      end
   endgenerate

   cov_e             sel_cov;
   logic [PTR_W-1:0] sel_slot;
   logic [DW-1:0]    fwd_data;

   always_comb begin
      sel_cov  = COV_NONE;
      sel_slot = '0;
      for (int k = 0; k < SLOTS; k++) begin
         logic [PTR_W-1:0] pos;
         pos = head + PTR_W'(k);
         if (k < int'(count) && slot_cand[pos] && slot_cov[pos] != COV_NONE) begin
            sel_cov  = slot_cov[pos];
            sel_slot = pos;
         end
      end
   end

   always_comb begin
      logic [OFF_W-1:0] off;
      logic [DW-1:0]    shifted;
      off      = OFF_W'(lk_addr - ent_addr[sel_slot]);
      shifted  = ent_data[sel_slot] >> {off, 3'b000};
      fwd_data = '0;
      for (int b = 0; b < DATA_BYTES; b++) begin
         if (b < int'(lk_size)) fwd_data[b*8 +: 8] = shifted[b*8 +: 8];
      end
      if (sel_cov != COV_FULL) fwd_data = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_done  <= 1'b0;
         lk_cover <= COV_NONE;
         lk_slot  <= '0;
         lk_data  <= '0;
      end else begin
         lk_done <= lk_valid;
         if (lk_valid) begin
            lk_cover <= sel_cov;
            lk_slot  <= sel_slot;
            lk_data  <= fwd_data;
         end
      end
   end

   // ---------------- assertions ----------------
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(SLOTS));

   assert_retry_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      retry_wait |-> iss_valid == '0);

   assert_unissued_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unissued <= count);

   assert_barrier_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bar_clr |-> !iss_valid[0]);

   assert_cover_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |-> lk_cover != 2'b11);
endmodule

// File: tb/test_stq_fwd_buffer.sv
module test_stq_fwd_buffer;
   localparam int SLOTS = 4, ADDR_W = 16, DATA_BYTES = 8, TID_W = 2, LANES = 2;
   localparam int PTR_W = 2, CNT_W = 3, SIZE_W = 4, DW = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                    ins_valid = 0, ins_barrier = 0, ins_cmo = 0;
   logic [TID_W-1:0]        ins_tid = 0;
   logic [ADDR_W-1:0]       ins_addr = 0;
   logic [SIZE_W-1:0]       ins_size = 0;
   logic [DW-1:0]           ins_data = 0;
   logic                    ins_ready;
   logic                    mem_ready = 0, mem_retry = 0, mem_ack = 0;
   logic [LANES-1:0]        mem_nack = 0;
   logic [PTR_W-1:0]        mem_ack_slot = 0;
   logic [LANES-1:0]        iss_valid;
   logic [LANES*ADDR_W-1:0] iss_addr;
   logic [LANES*SIZE_W-1:0] iss_size;
   logic [LANES*DW-1:0]     iss_data;
   logic [LANES*PTR_W-1:0]  iss_slot;
   logic                    lk_valid = 0;
   logic [TID_W-1:0]        lk_tid = 0;
   logic [ADDR_W-1:0]       lk_addr = 0;
   logic [SIZE_W-1:0]       lk_size = 0;
   logic                    lk_done;
   logic [1:0]              lk_cover;
   logic [PTR_W-1:0]        lk_slot;
   logic [DW-1:0]           lk_data;
   logic                    bar_clr;
   logic [CNT_W-1:0]        unissued;

   int checks = 0;
   int fails  = 0;

   stq_fwd_buffer #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES),
                    .TID_W(TID_W), .LANES(LANES)) i_stq_fwd_buffer (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_barrier(ins_barrier), .ins_cmo(ins_cmo),
      .ins_tid(ins_tid), .ins_addr(ins_addr), .ins_size(ins_size),
      .ins_data(ins_data), .ins_ready(ins_ready),
      .mem_ready(mem_ready), .mem_nack(mem_nack), .mem_retry(mem_retry),
      .mem_ack(mem_ack), .mem_ack_slot(mem_ack_slot),
      .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_size(iss_size),
      .iss_data(iss_data), .iss_slot(iss_slot),
      .lk_valid(lk_valid), .lk_tid(lk_tid), .lk_addr(lk_addr), .lk_size(lk_size),
      .lk_done(lk_done), .lk_cover(lk_cover), .lk_slot(lk_slot), .lk_data(lk_data),
      .bar_clr(bar_clr), .unissued(unissued));

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic put(input logic bar, input logic cmo, input logic [1:0] tid,
                      input logic [15:0] addr, input logic [3:0] size, input logic [63:0] data);
      ins_valid = 1; ins_barrier = bar; ins_cmo = cmo; ins_tid = tid;
      ins_addr = addr; ins_size = size; ins_data = data;
      step();
      ins_valid = 0; ins_barrier = 0; ins_cmo = 0;
   endtask

   task automatic look(input string req, input logic [1:0] tid, input logic [15:0] addr,
                       input logic [3:0] size, input logic [1:0] exp_cov,
                       input logic [1:0] exp_slot, input logic [63:0] exp_data);
      lk_valid = 1; lk_tid = tid; lk_addr = addr; lk_size = size;
      step();
      lk_valid = 0;
      check(req, "lk_done", 64'(lk_done), 64'd1);
      check(req, "lk_cover", 64'(lk_cover), 64'(exp_cov));
      if (exp_cov != 2'b00) check(req, "lk_slot", 64'(lk_slot), 64'(exp_slot));
      check(req, "lk_data", lk_data, exp_data);
   endtask

   task automatic ack(input logic [1:0] slot);
      mem_ack = 1; mem_ack_slot = slot;
      step();
      mem_ack = 0;
   endtask

   task automatic t_reset();
      mem_ready = 1;
      #1;
      check("R1", "ins_ready", 64'(ins_ready), 64'd1);
      check("R1", "unissued", 64'(unissued), 64'd0);
      check("R1", "iss_valid", 64'(iss_valid), 64'd0);
      check("R1", "bar_clr", 64'(bar_clr), 64'd0);
      check("R1", "lk_done", 64'(lk_done), 64'd0);
      mem_ready = 0;
   endtask

   task automatic t_fill();
      put(0, 0, 2'd0, 16'h0100, 4'd8, 64'h8877665544332211);
      put(0, 0, 2'd0, 16'h0104, 4'd4, 64'h00000000AABBCCDD);
      put(0, 0, 2'd1, 16'h0100, 4'd8, 64'h0102030405060708);
      put(0, 1, 2'd0, 16'h0200, 4'd4, 64'h0);
      check("R2", "ins_ready full", 64'(ins_ready), 64'd0);
      check("R10", "unissued after 4", 64'(unissued), 64'd4);
      put(0, 0, 2'd0, 16'h0900, 4'd1, 64'hEE);   // refused: buffer full
      check("R2", "unissued after refused insert", 64'(unissued), 64'd4);
   endtask

   task automatic t_lookup();
      look("R6",  2'd0, 16'h0102, 4'd2, 2'b10, 2'd0, 64'h4433);
      look("R4",  2'd0, 16'h0103, 4'd2, 2'b01, 2'd1, 64'h0);
      look("R4",  2'd0, 16'h0104, 4'd4, 2'b10, 2'd1, 64'hAABBCCDD);
      look("R5",  2'd0, 16'h0200, 4'd2, 2'b00, 2'd0, 64'h0);
      look("R5",  2'd1, 16'h0104, 4'd2, 2'b10, 2'd2, 64'h0304);
      look("R5",  2'd2, 16'h0100, 4'd1, 2'b00, 2'd0, 64'h0);
      look("R3",  2'd0, 16'h0108, 4'd2, 2'b00, 2'd0, 64'h0);
      look("R3",  2'd0, 16'h00FE, 4'd4, 2'b01, 2'd0, 64'h0);
   endtask

   task automatic t_issue();
      mem_ready = 1;
      #1;
      check("R7", "two lanes", 64'(iss_valid), 64'b11);
      check("R7", "lane0 slot", 64'(iss_slot[1:0]), 64'd0);
      check("R7", "lane1 slot", 64'(iss_slot[3:2]), 64'd1);
      check("R7", "lane1 addr", 64'(iss_addr[31:16]), 64'h0104);
      check("R7", "lane1 size", 64'(iss_size[7:4]), 64'd4);
      step();
      mem_ready = 0;
      #1;
      check("R7", "no lane when not ready", 64'(iss_valid), 64'b00);
      check("R10", "unissued after 2 sent", 64'(unissued), 64'd2);
   endtask

   task automatic t_nack();
      mem_ready = 1; mem_nack = 2'b10;
      #1;
      check("R7", "lanes slots 2,3", 64'(iss_slot), 64'({2'd3, 2'd2}));
      step();
      mem_nack = 2'b00;
      #1;
      check("R8", "wait after nack", 64'(iss_valid), 64'b00);
      check("R8", "refused stays unsent", 64'(unissued), 64'd1);
      step();
      check("R8", "still waiting", 64'(iss_valid), 64'b00);
      mem_retry = 1;
      step();
      mem_retry = 0;
      #1;
      check("R8", "resume after retry", 64'(iss_valid), 64'b01);
      check("R8", "refused slot reissued", 64'(iss_slot[1:0]), 64'd3);
      step();
      mem_ready = 0;
      check("R10", "all sent", 64'(unissued), 64'd0);
   endtask

   task automatic t_ack();
      ack(2'd1);
      step(); step();
      check("R11", "younger ack frees nothing", 64'(ins_ready), 64'd0);
      ack(2'd0);
      step(); step();
      check("R11", "head entries freed", 64'(ins_ready), 64'd1);
      look("R11", 2'd0, 16'h0104, 4'd4, 2'b00, 2'd0, 64'h0);
      look("R2",  2'd0, 16'h0900, 4'd1, 2'b00, 2'd0, 64'h0);
      look("R11", 2'd1, 16'h0104, 4'd2, 2'b10, 2'd2, 64'h0304);
      ack(2'd2);
      ack(2'd3);
      step(); step(); step();
   endtask

   task automatic t_barrier();
      put(0, 0, 2'd0, 16'h0300, 4'd4, 64'h11223344);
      put(1, 0, 2'd0, 16'h0000, 4'd0, 64'h0);
      put(0, 0, 2'd0, 16'h0310, 4'd2, 64'h5566);
      check("R10", "unissued with barrier", 64'(unissued), 64'd3);
      mem_ready = 1;
      #1;
      check("R9", "only store before barrier", 64'(iss_valid), 64'b01);
      check("R9", "lane0 addr", 64'(iss_addr[15:0]), 64'h0300);
      step();
      #1;
      check("R9", "barrier holds younger store", 64'(iss_valid), 64'b00);
      check("R9", "no clear yet", 64'(bar_clr), 64'd0);
      check("R10", "unissued after first", 64'(unissued), 64'd2);
      ack(2'd0);
      step();
      #1;
      check("R9", "clear pulse at head", 64'(bar_clr), 64'd1);
      check("R9", "still held", 64'(iss_valid), 64'b00);
      step();
      #1;
      check("R9", "clear pulse ends", 64'(bar_clr), 64'd0);
      check("R10", "barrier removal counted", 64'(unissued), 64'd1);
      check("R9", "younger store offered", 64'(iss_valid), 64'b01);
      check("R9", "younger addr", 64'(iss_addr[15:0]), 64'h0310);
      step();
      mem_ready = 0;
      check("R10", "all sent after barrier", 64'(unissued), 64'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_fill();
      t_lookup();
      t_issue();
      t_nack();
      t_ack();
      t_barrier();
      step();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule